// File: doc/BRIEF.md
# Upper-Memory Shadow Route Decoder

This block sits beside the memory controller and decides, for every access that falls in the upper-memory area (0xC0000 to 0xFFFFF), whether the access is served by on-board DRAM or is passed to the external expansion bus. The decision is made from the access address, its direction, and three 8-bit control bytes. The control bytes are held in a register file elsewhere and are fed in as plain levels.

The 0xC0000–0xDFFFF span is split into eight 16 KB granules. Each granule has its own 2-bit routing code: four codes are packed into the low control byte and four into the middle control byte. The 0xE0000–0xFFFFF span is split into two 64 KB granules. Their codes sit in the upper nibble of the high control byte, and the lower nibble of that byte is unused.

Within a code, one bit selects DRAM for reads and the other selects DRAM for writes. The block also reports whether the system firmware area at 0xF0000 is currently read from DRAM. The decode is combinational. There is no stream traffic, so every pin is a plain level and there is no valid/ready handshake.

Top module: `shadow_route_decoder`

## Requirements
- R1: For a read (`acc_write`=0) inside the window, `to_dram` equals bit 1 of the selected granule's 2-bit code. A 0 in that bit routes the read to the expansion bus.
- R2: For a write (`acc_write`=1) inside the window, `to_dram` equals bit 0 of the selected granule's code. A 0 in that bit routes the write to the expansion bus.
- R3: `ctl_c_seg` holds the codes for 0xC0000, 0xC4000, 0xC8000 and 0xCC000 in bits [1:0], [3:2], [5:4] and [7:6] respectively.
- R4: `ctl_d_seg` holds the codes for 0xD0000, 0xD4000, 0xD8000 and 0xDC000 in bits [1:0], [3:2], [5:4] and [7:6] respectively.
- R5: `ctl_ef_seg` bits [7:6] are the code for the 64 KB granule at 0xE0000.
- R6: `ctl_ef_seg` bits [5:4] are the code for the 64 KB granule at 0xF0000.
- R7: `bios_shadowed` equals the read bit of the 0xF0000 code (`ctl_ef_seg` bit 5), whatever the address.
- R8: Addresses below 0xC0000 drive `in_window` low and `to_dram` low, for any control values.
- R9: `ctl_ef_seg` bits [3:0] have no effect on `to_dram` or `in_window`.
- R10: The outputs depend only on the present inputs and hold no state. A change on any input is reflected within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | 20 | Physical address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| ctl_c_seg | input | 8 | Four 2-bit codes for 0xC0000–0xCFFFF |
| ctl_d_seg | input | 8 | Four 2-bit codes for 0xD0000–0xDFFFF |
| ctl_ef_seg | input | 8 | Codes for 0xF0000 ([5:4]) and 0xE0000 ([7:6]); [3:0] unused |
| to_dram | output | 1 | 1 routes the access to on-board DRAM, 0 to the expansion bus |
| in_window | output | 1 | 1 when the address lies in 0xC0000–0xFFFFF |
| bios_shadowed | output | 1 | 1 when firmware-area reads come from DRAM |

## Verification
The inline assertions check several properties on every evaluation:
- Outside the window, `to_dram` stays low.
- All-zero codes never select DRAM.
- All-one codes select DRAM everywhere inside the window.
- For a read in the 0xF0000 granule, `to_dram` matches `bios_shadowed`.

Other behaviours can only be shown by the bench scenarios, which compare against a behavioural model on every clock:
- Each code maps to its own granule, which needs distinct codes placed in neighbouring fields.
- The read bit and the write bit each have an independent effect.
- The unused nibble has no influence.
- The outputs follow inputs that change every cycle.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned RD_BIT   = 1;
  localparam int unsigned WR_BIT   = 0;
  typedef logic [CODE_W-1:0] route_code_t;
endpackage

// File: rtl/shadow_field_pick.sv
module shadow_field_pick
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned CTL_W      = 8,
  parameter int unsigned SMALL_LOG2 = 14,
  parameter int unsigned LARGE_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  ctl_c,
  input  logic [CTL_W-1:0]  ctl_d,
  input  logic [CTL_W-1:0]  ctl_ef,
  output route_code_t       code,
  output logic              window
);
  localparam int unsigned PER_BYTE  = CTL_W / CODE_W;
  localparam int unsigned SMALL_CNT = 2 * PER_BYTE;
  localparam int unsigned IDX_W     = $clog2(SMALL_CNT);
  localparam int unsigned HALF_BIT  = LARGE_LOG2 + 1;
  localparam int unsigned E_LSB     = CTL_W - CODE_W;
  localparam int unsigned F_LSB     = CTL_W - 2 * CODE_W;

  route_code_t small_code [SMALL_CNT];

  for (genvar g = 0; g < SMALL_CNT; g++) begin : g_small
    if (g < PER_BYTE) begin : g_c
      assign small_code[g] = ctl_c[g*CODE_W +: CODE_W];
    end else begin : g_d
      assign small_code[g] = ctl_d[(g-PER_BYTE)*CODE_W +: CODE_W];
    end
  end

  logic [IDX_W-1:0] small_idx;
  route_code_t      large_code;

  assign small_idx  = addr[SMALL_LOG2 +: IDX_W];
  assign large_code = addr[LARGE_LOG2] ? ctl_ef[F_LSB +: CODE_W]
                                       : ctl_ef[E_LSB +: CODE_W];
  assign window     = (addr[ADDR_W-1 -: 2] == 2'b11);

  always_comb begin
    if (!window)              code = '0;
    else if (addr[HALF_BIT])  code = large_code;
    else                      code = small_code[small_idx];
  end

  // R9: with a zeroed upper nibble, the high granules select code 0 whatever the low nibble holds
  always_comb begin
    if (window && addr[HALF_BIT] && ctl_ef[CTL_W-1:F_LSB] == '0)
      a_r9_low_nibble_inert: assert (code == '0);
  end
endmodule

// File: rtl/shadow_route_apply.sv
module shadow_route_apply
  import shadow_pkg::*;
(
  input  route_code_t code,
  input  logic        window,
  input  logic        is_write,
  output logic        route
);
  always_comb begin
    route = 1'b0;
    if (window) route = is_write ? code[WR_BIT] : code[RD_BIT];
  end

  // R1 R2: code 0 always goes to the expansion bus, code 3 always to DRAM
  always_comb begin
    if (window && code == '0) a_r1_zero_code_external: assert (!route);
    if (window && code == '1) a_r2_full_code_internal: assert (route);
  end
endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned CTL_W      = 8,
  parameter int unsigned SMALL_LOG2 = 14,
  parameter int unsigned LARGE_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [CTL_W-1:0]  ctl_c_seg,
  input  logic [CTL_W-1:0]  ctl_d_seg,
  input  logic [CTL_W-1:0]  ctl_ef_seg,
  output logic              to_dram,
  output logic              in_window,
  output logic              bios_shadowed
);
  localparam int unsigned F_RD_BIT = CTL_W - 2 * CODE_W + RD_BIT;

  route_code_t sel_code;
  logic        win;

  shadow_field_pick #(
    .ADDR_W(ADDR_W), .CTL_W(CTL_W),
    .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)
  ) u_pick (
    .addr(acc_addr), .ctl_c(ctl_c_seg), .ctl_d(ctl_d_seg),
    .ctl_ef(ctl_ef_seg), .code(sel_code), .window(win)
  );

  shadow_route_apply u_apply (
    .code(sel_code), .window(win), .is_write(acc_write), .route(to_dram)
  );

  assign in_window     = win;
  assign bios_shadowed = ctl_ef_seg[F_RD_BIT];

  always_comb begin
    // R8: nothing outside the window reaches DRAM
    if (!in_window) a_r8_outside_external: assert (!to_dram);
    // R7: a firmware-area read follows the shadowed indication
    if (in_window && acc_addr[LARGE_LOG2+1] && acc_addr[LARGE_LOG2] && !acc_write)
      a_r7_bios_read_agrees: assert (to_dram == bios_shadowed);
    // R3 R4: all-zero control bytes keep every access on the expansion bus
    if (ctl_c_seg == '0 && ctl_d_seg == '0 && ctl_ef_seg[CTL_W-1 -: 2*CODE_W] == '0)
      a_r3_all_clear_external: assert (!to_dram);
    // R5 R6: all-one control bytes send every in-window access to DRAM
    if (&ctl_c_seg && &ctl_d_seg && &ctl_ef_seg[CTL_W-1 -: 2*CODE_W])
      a_r5_all_set_internal: assert (to_dram == in_window);
  end
endmodule

// File: tb/tb_shadow_route_decoder.sv
`timescale 1ns/1ps
module tb_shadow_route_decoder;
  logic        clk = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [7:0]  ctl_c_seg = '0, ctl_d_seg = '0, ctl_ef_seg = '0;
  logic        to_dram, in_window, bios_shadowed;
  int          n_checks = 0, n_fail = 0, cycles = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  shadow_route_decoder dut (
    .acc_addr(acc_addr), .acc_write(acc_write), .ctl_c_seg(ctl_c_seg),
    .ctl_d_seg(ctl_d_seg), .ctl_ef_seg(ctl_ef_seg), .to_dram(to_dram),
    .in_window(in_window), .bios_shadowed(bios_shadowed)
  );

  function automatic bit [2:0] model(int addr, bit wr, int c, int d, int ef);
    int code;
    bit win;
    win = (addr >= 'hC0000) && (addr < 'h100000);
    if (!win)                 code = 0;
    else if (addr < 'hD0000)  code = (c >> (((addr - 'hC0000) / 'h4000) * 2)) & 3;
    else if (addr < 'hE0000)  code = (d >> (((addr - 'hD0000) / 'h4000) * 2)) & 3;
    else if (addr < 'hF0000)  code = (ef >> 6) & 3;
    else                      code = (ef >> 4) & 3;
    return {win && (wr ? (code % 2 == 1) : (code / 2 == 1)), win, ((ef >> 5) & 1) == 1};
  endfunction

  task automatic apply(string req, int addr, bit wr, int c, int d, int ef);
    bit [2:0] exp;
    @(posedge clk);
    acc_addr = addr[19:0]; acc_write = wr;
    ctl_c_seg = c[7:0]; ctl_d_seg = d[7:0]; ctl_ef_seg = ef[7:0];
    @(negedge clk);
    exp = model(addr, wr, c, d, ef);
    n_checks++;
    if ({to_dram, in_window, bios_shadowed} !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0d ctl=%h/%h/%h actual=%b expected=%b",
               req, addr, wr, c, d, ef, {to_dram, in_window, bios_shadowed}, exp);
    end
  endtask

  initial begin
    // reset-like state: all controls clear
    apply("R1 reset", 'hC0000, 0, 0, 0, 0);
    apply("R2 reset", 'hFFFFF, 1, 0, 0, 0);
    // R3 and R4: each granule with each code, neighbours at the complement and at zero
    for (int g = 0; g < 4; g++)
      for (int code = 0; code < 4; code++)
        for (int wr = 0; wr < 2; wr++) begin
          int fld, off;
          fld = 'hFF ^ (((~code) & 3) << (2*g));
          off = $urandom_range(0, 'h3FFF);
          apply("R3 R1 R2", 'hC0000 + g*'h4000 + off, wr[0], fld, 0, 0);
          apply("R3 R1 R2", 'hC0000 + g*'h4000 + off, wr[0], code << (2*g), 'hFF, 'hF0);
          apply("R4 R1 R2", 'hD0000 + g*'h4000 + off, wr[0], 0, fld, 0);
          apply("R4 R1 R2", 'hD0000 + g*'h4000 + off, wr[0], 'hFF, code << (2*g), 'hF0);
        end
    // R5 R6 R7: upper granules, all nibble values
    for (int ef = 0; ef < 256; ef += 16)
      for (int wr = 0; wr < 2; wr++) begin
        apply("R5", 'hE0000 + $urandom_range(0, 'hFFFF), wr[0], 0, 0, ef);
        apply("R6 R7", 'hF0000 + $urandom_range(0, 'hFFFF), wr[0], 'hFF, 'hFF, ef);
        apply("R7", $urandom_range(0, 'hBFFFF), wr[0], 0, 0, ef);
      end
    // R8: below the window, everything set
    apply("R8", 'hBFFFF, 0, 'hFF, 'hFF, 'hFF);
    apply("R8", 'h00000, 1, 'hFF, 'hFF, 'hFF);
    for (int i = 0; i < 20; i++)
      apply("R8", $urandom_range(0, 'hBFFFF), i[0], 'hFF, 'hFF, 'hFF);
    // R9: the low nibble of the high byte must not matter
    for (int lo = 0; lo < 16; lo++) begin
      apply("R9", 'hE4000, 0, 0, 0, 'h80 | lo);
      apply("R9", 'hF8000, 1, 0, 0, 'h10 | lo);
      apply("R9", 'hCC000, 0, 'h00, 'h00, lo);
    end
    // R10: all inputs change every cycle
    for (int i = 0; i < 2000; i++)
      apply("R10", $urandom_range(0, 'hFFFFF), i[1] ^ i[3], $urandom_range(0, 255),
            $urandom_range(0, 255), $urandom_range(0, 255));
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 100000) begin
      if (!done) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule